// File: doc/BRIEF.md
# SPI Flash Word-Storage Controller

This block keeps 32-bit data words in a small SPI serial flash that serves as non-volatile storage. It drives chip select, serial clock and serial data-out, samples serial data-in, and turns three simple user requests into complete flash command sequences. The three requests are read a word, erase a sector and program a word. Each request carries a 24-bit byte address, and a program request also carries a 32-bit data word.

Each erase or program is sent as its own transaction, after a separate write-enable transaction. Chip select is raised between the two. The block then polls the flash status register until the write-in-progress flag clears, and only then reports completion. To update a stored word, the user issues an erase request and then a program request. After reset the block fetches two words from two fixed addresses, which lie in different sectors, and holds them on dedicated outputs. The serial link runs in SPI mode 0. The serial clock is a programmable division of the system clock, and chip select stays high for a guaranteed minimum time between transactions.

Top module: `spif_word_store`

## Requirements
- R1: A read request sends opcode 0x03, then the 24-bit address MSB first, then clocks in 32 bits MSB first. The first received byte comes from the requested address and becomes the top byte of `rd_data`, which is updated when `done` pulses.
- R2: An erase request runs a write-enable transaction (opcode 0x06, one byte) and raises chip select. It then runs a sector-erase transaction of opcode 0xD8 plus the 24-bit address, which is exactly 4 bytes.
- R3: A program request runs a write-enable transaction and raises chip select. It then runs opcode 0x02, the 24-bit address and the 4 data bytes MSB first, which is 8 bytes.
- R4: After each erase or program, the block repeats one-byte-plus-status transactions (opcode 0x05, then one status byte read back). It continues while status bit 0 (write in progress) reads 1, and asserts `done` only after a poll that returns bit 0 = 0.
- R5: After reset the block, with `busy` high, reads the word at `BOOT_ADDR0` and then the word at `BOOT_ADDR1`, using exactly two read transactions. It presents them on `boot_word0` and `boot_word1`, then sets `boot_valid`, which stays set until the next reset.
- R6: SPI mode 0 applies. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` never changes while `spi_sclk` is high, and it is set up at least one system clock before each rising edge.
- R7: `spi_cs_n` stays high for at least `CSH_CYC` system clocks between transactions. Each serial clock high and low phase lasts at least `DIV` system clocks.
- R8: Requests that arrive while `busy` is high are ignored and start no transaction.
- R9: When several requests are raised together while idle, read wins over erase, and erase wins over program.
- R10: `done` is a single-cycle pulse, and `busy` is low in that cycle.
- R11: While `rst` is high, `spi_cs_n` is 1, `spi_sclk` is 0, and `done` and `boot_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_read | input | 1 | Request: read the word at `req_addr` |
| req_erase | input | 1 | Request: erase the sector containing `req_addr` |
| req_prog | input | 1 | Request: program `req_data` at `req_addr` |
| req_addr | input | 24 | Byte address for the request |
| req_data | input | 32 | Word to program |
| busy | output | 1 | A sequence is in progress; requests ignored |
| done | output | 1 | One-cycle completion pulse for user requests |
| rd_data | output | 32 | Word returned by the last read request |
| boot_word0 | output | 32 | Word read from `BOOT_ADDR0` after reset |
| boot_word1 | output | 32 | Word read from `BOOT_ADDR1` after reset |
| boot_valid | output | 1 | Both startup words are present |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A request is taken at the first rising edge where it is high while idle, so `busy` reads 1 at the following falling edge. The bench samples there and then counts falling edges until the `done` pulse. That pulse comes one cycle after the last chip-select rise plus `CSH_CYC` gap cycles, after several hundred cycles for a read and after every status poll for an erase or program. Values checked against `done` are read in the same half cycle, and the pulse width is confirmed on the next falling edge. The bench's flash model timestamps every serial edge and chip-select edge in real time. From those stamps it judges setup, stability, phase lengths and gaps without depending on any fixed cycle count.

// File: rtl/spif_pkg.sv
package spif_pkg;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_ERASE = 8'hD8;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;

    localparam int ADDR_W = 24;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        PH_INIT, PH_BOOT0, PH_BOOT1, PH_READ,
        PH_WREN_E, PH_ERASE, PH_WREN_P, PH_PROG, PH_POLL
    } phase_e;

    typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_SHIFT, ST_GAP} state_e;

    typedef struct packed {
        phase_e              ph;
        logic [ADDR_W-1:0]   addr;
        logic [WORD_W-1:0]   data;
    } job_t;

    function automatic logic is_read(phase_e ph);
        return (ph == PH_BOOT0) || (ph == PH_BOOT1) || (ph == PH_READ);
    endfunction

    function automatic logic [2:0] last_idx(phase_e ph);
        case (ph)
            PH_WREN_E, PH_WREN_P: return 3'd0;
            PH_POLL:              return 3'd1;
            PH_ERASE:             return 3'd3;
            default:              return 3'd7;
        endcase
    endfunction

    function automatic logic [7:0] opcode(phase_e ph);
        case (ph)
            PH_WREN_E, PH_WREN_P: return OP_WREN;
            PH_ERASE:             return OP_ERASE;
            PH_PROG:              return OP_PROG;
            PH_POLL:              return OP_RDSR;
            default:              return OP_READ;
        endcase
    endfunction

    function automatic logic [7:0] tx_byte(phase_e ph, logic [2:0] idx,
                                           logic [ADDR_W-1:0] a,
                                           logic [WORD_W-1:0] d);
        if (idx == 3'd0) return opcode(ph);
        if (ph == PH_POLL) return 8'h00;
        case (idx)
            3'd1:    return a[23:16];
            3'd2:    return a[15:8];
            3'd3:    return a[7:0];
            3'd4:    return d[31:24];
            3'd5:    return d[23:16];
            3'd6:    return d[15:8];
            default: return d[7:0];
        endcase
    endfunction

endpackage

// File: rtl/spif_clkdiv.sv
module spif_clkdiv #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)  cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spif_byte_engine.sv
module spif_byte_engine (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] tx,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    logic [7:0] sh_q;
    logic [7:0] rx_q;
    logic [2:0] bit_q;
    logic       act_q;
    logic       sclk_q;
    logic       done_q;

    assign mosi = sh_q[7];
    assign sclk = sclk_q;
    assign rx   = rx_q;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            act_q  <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !act_q) begin
                act_q  <= 1'b1;
                sh_q   <= tx;
                bit_q  <= '0;
                sclk_q <= 1'b0;
            end else if (act_q && tick) begin
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spif_word_store.sv
module spif_word_store
    import spif_pkg::*;
#(
    parameter int          DIV        = 2,
    parameter int          CSH_CYC    = 4,
    parameter logic [23:0] BOOT_ADDR0 = 24'h000000,
    parameter logic [23:0] BOOT_ADDR1 = 24'h010000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_read,
    input  logic        req_erase,
    input  logic        req_prog,
    input  logic [23:0] req_addr,
    input  logic [31:0] req_data,
    output logic        busy,
    output logic        done,
    output logic [31:0] rd_data,
    output logic [31:0] boot_word0,
    output logic [31:0] boot_word1,
    output logic        boot_valid,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int GW = (CSH_CYC > 1) ? $clog2(CSH_CYC) : 1;

    state_e          st_q;
    job_t            job_q;
    logic [2:0]      idx_q;
    logic [GW-1:0]   gcnt_q;
    logic [31:0]     word_q;
    logic            wip_q;
    logic            cs_q;
    logic            done_q;
    logic            bv_q;
    logic [31:0]     b0_q, b1_q, rd_q;

    logic            eng_start, eng_done, tick;
    logic [7:0]      eng_rx, eng_tx;
    logic [31:0]     full_w;

    assign eng_start = (st_q == ST_LAUNCH);
    assign eng_tx    = tx_byte(job_q.ph, idx_q, job_q.addr, job_q.data);
    assign full_w    = {word_q[23:0], eng_rx};

    spif_clkdiv #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .clear(eng_start), .tick(tick)
    );

    spif_byte_engine u_eng (
        .clk(clk), .rst(rst), .tick(tick), .start(eng_start), .tx(eng_tx),
        .done(eng_done), .rx(eng_rx), .sclk(spi_sclk), .mosi(spi_mosi),
        .miso(spi_miso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_GAP;
            job_q  <= '{ph: PH_INIT, addr: '0, data: '0};
            idx_q  <= '0;
            gcnt_q <= '0;
            word_q <= '0;
            wip_q  <= 1'b0;
            cs_q   <= 1'b1;
            done_q <= 1'b0;
            bv_q   <= 1'b0;
            b0_q   <= '0;
            b1_q   <= '0;
            rd_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (req_read) begin
                        job_q <= '{ph: PH_READ, addr: req_addr, data: req_data};
                        st_q  <= ST_LAUNCH;
                    end else if (req_erase) begin
                        job_q <= '{ph: PH_WREN_E, addr: req_addr, data: req_data};
                        st_q  <= ST_LAUNCH;
                    end else if (req_prog) begin
                        job_q <= '{ph: PH_WREN_P, addr: req_addr, data: req_data};
                        st_q  <= ST_LAUNCH;
                    end
                end
                ST_LAUNCH: begin
                    cs_q <= 1'b0;
                    st_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (eng_done) begin
                        if (is_read(job_q.ph) && idx_q >= 3'd4) word_q <= full_w;
                        if (job_q.ph == PH_POLL && idx_q == 3'd1) wip_q <= eng_rx[0];
                        if (idx_q == last_idx(job_q.ph)) begin
                            cs_q   <= 1'b1;
                            gcnt_q <= '0;
                            st_q   <= ST_GAP;
                            if (job_q.ph == PH_BOOT0) b0_q <= full_w;
                            if (job_q.ph == PH_BOOT1) b1_q <= full_w;
                            if (job_q.ph == PH_READ)  rd_q <= full_w;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= ST_LAUNCH;
                        end
                    end
                end
                ST_GAP: begin
                    if (gcnt_q == GW'(CSH_CYC - 1)) begin
                        idx_q <= '0;
                        st_q  <= ST_LAUNCH;
                        case (job_q.ph)
                            PH_INIT: begin
                                job_q.ph   <= PH_BOOT0;
                                job_q.addr <= BOOT_ADDR0;
                            end
                            PH_BOOT0: begin
                                job_q.ph   <= PH_BOOT1;
                                job_q.addr <= BOOT_ADDR1;
                            end
                            PH_BOOT1: begin
                                bv_q <= 1'b1;
                                st_q <= ST_IDLE;
                            end
                            PH_READ: begin
                                done_q <= 1'b1;
                                st_q   <= ST_IDLE;
                            end
                            PH_WREN_E: job_q.ph <= PH_ERASE;
                            PH_WREN_P: job_q.ph <= PH_PROG;
                            PH_ERASE, PH_PROG: job_q.ph <= PH_POLL;
                            PH_POLL: begin
                                if (!wip_q) begin
                                    done_q <= 1'b1;
                                    st_q   <= ST_IDLE;
                                end
                            end
                            default: st_q <= ST_IDLE;
                        endcase
                    end else begin
                        gcnt_q <= gcnt_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st_q != ST_IDLE);
    assign done       = done_q;
    assign rd_data    = rd_q;
    assign boot_word0 = b0_q;
    assign boot_word1 = b1_q;
    assign boot_valid = bv_q;
    assign spi_cs_n   = cs_q;
endmodule

// File: rtl/spif_word_store_chk.sv
module spif_word_store_chk #(
    parameter int CSH_CYC = 4
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic boot_valid,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    localparam int HW = $clog2(CSH_CYC + 2) + 1;
    logic [HW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst)                     high_cnt <= '0;
        else if (!spi_cs_n)          high_cnt <= '0;
        else if (high_cnt < HW'(CSH_CYC + 1)) high_cnt <= high_cnt + 1'b1;
    end

    // R6: serial clock idles low with chip select high
    a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R6: data out holds while the serial clock is high
    a_r6_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> $stable(spi_mosi));

    // R7: chip select high time before each new transaction
    a_r7_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> ($past(high_cnt) >= HW'(CSH_CYC)));

    // R10: done is one cycle and never with busy
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: startup words stay valid once present
    a_r5_boot_sticky: assert property (@(posedge clk) disable iff (rst)
        boot_valid |=> boot_valid);

    // R8: no transaction starts while idle
    a_r8_no_idle_txn: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> spi_cs_n);
endmodule

bind spif_word_store spif_word_store_chk #(.CSH_CYC(CSH_CYC)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .boot_valid(boot_valid),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/spif_word_store_tb.sv
`timescale 1ns/1ps
module spif_word_store_tb;
    localparam int DIV = 2;
    localparam int CSH = 4;
    localparam logic [23:0] BA0 = 24'h000010;
    localparam logic [23:0] BA1 = 24'h000124;
    localparam int WIP_N = 3;
    localparam real TCK = 5.0;

    logic clk = 1'b0, rst = 1'b1;
    logic req_read = 0, req_erase = 0, req_prog = 0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic busy, done, boot_valid, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
    logic [31:0] rd_data, boot_word0, boot_word1;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    spif_word_store #(.DIV(DIV), .CSH_CYC(CSH), .BOOT_ADDR0(BA0), .BOOT_ADDR1(BA1)) u_dut (
        .clk(clk), .rst(rst), .req_read(req_read), .req_erase(req_erase),
        .req_prog(req_prog), .req_addr(req_addr), .req_data(req_data),
        .busy(busy), .done(done), .rd_data(rd_data), .boot_word0(boot_word0),
        .boot_word1(boot_word1), .boot_valid(boot_valid), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- flash model ----------------
    logic [7:0] mem [0:1023];
    logic [7:0] expm [0:1023];
    logic [7:0] rxb [0:15];
    logic [7:0] cur, out_b;
    logic miso_q = 1'b0;
    int bitc = 0, nb = 0, wip_left = 0, wel = 0;
    int txn = 0, polls = 0, erases = 0, progs = 0, reads = 0, perr = 0;
    logic [7:0] last_op = 8'h00;
    realtime t_cs_rise = 0, t_rise = 0, t_mosi = 0;
    assign spi_miso = miso_q;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) ^ (i >> 3));
    endfunction

    function automatic int maddr();
        return {rxb[2][1:0], rxb[3]};
    endfunction

    always @(spi_mosi) t_mosi = $realtime;

    always @(negedge spi_cs_n) begin
        bitc = 0; nb = 0; txn++;
        if (t_cs_rise > 0 && ($realtime - t_cs_rise) < CSH * TCK - 0.1) perr++;
        if (spi_sclk) perr++;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        if (($realtime - t_mosi) < TCK - 0.1) perr++;
        t_rise = $realtime;
        cur = {cur[6:0], spi_mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            if (nb < 16) rxb[nb] = cur;
            nb++;
            out_b = 8'h00;
            if (rxb[0] == 8'h03 && nb >= 4) out_b = mem[(maddr() + nb - 4) % 1024];
            if (rxb[0] == 8'h05) out_b = {7'd0, wip_left != 0};
        end
    end

    always @(negedge spi_sclk) if (!spi_cs_n) begin
        if (($realtime - t_rise) < DIV * TCK - 0.1) perr++;
        if (t_mosi > t_rise && t_mosi != $realtime) perr++;
        miso_q = out_b[7];
        out_b  = {out_b[6:0], 1'b0};
    end

    always @(posedge spi_cs_n) begin
        t_cs_rise = $realtime;
        if (nb != 0) begin
            if (spi_sclk || bitc != 0) perr++;
            last_op = rxb[0];
            case (rxb[0])
                8'h06: if (nb == 1) wel = 1; else perr++;
                8'h05: begin polls++; if (wip_left > 0) wip_left--; end
                8'h03: reads++;
                8'hD8: if (nb == 4 && wel == 1 && wip_left == 0) begin
                           for (int i = 0; i < 256; i++) mem[(maddr() & 768) + i] = 8'hFF;
                           wel = 0; wip_left = WIP_N; erases++;
                       end else perr++;
                8'h02: if (nb == 8 && wel == 1 && wip_left == 0) begin
                           for (int i = 0; i < 4; i++)
                               mem[(maddr() + i) % 1024] = mem[(maddr() + i) % 1024] & rxb[4+i];
                           wel = 0; wip_left = WIP_N; progs++;
                       end else perr++;
                default: perr++;
            endcase
        end
    end

    // ---------------- bench helpers ----------------
    function automatic logic [31:0] exp_word(int a);
        return {expm[a % 1024], expm[(a+1) % 1024], expm[(a+2) % 1024], expm[(a+3) % 1024]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic request(input logic r, input logic e, input logic p,
                           input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        req_read = r; req_erase = e; req_prog = p; req_addr = a; req_data = d;
        @(negedge clk);
        req_read = 0; req_erase = 0; req_prog = 0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        chk(done === 1'b1, {tag, " done seen"}, 32'(done), 32'd1);
        chk(busy === 1'b0, "R10 busy low with done", 32'(busy), 32'd0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic do_read(input int a, input string tag);
        request(1, 0, 0, 24'(a), 32'd0);
        chk(busy === 1'b1, "R8 busy after accept", 32'(busy), 32'd1);
        wait_done(tag);
        chk(rd_data === exp_word(a), tag, rd_data, exp_word(a));
    endtask

    task automatic do_erase(input int a, input string tag);
        int p0 = polls, t0 = txn;
        request(0, 1, 0, 24'(a), 32'd0);
        wait_done(tag);
        for (int i = 0; i < 256; i++) expm[(a & 768) + i] = 8'hFF;
        chk(polls - p0 == WIP_N + 1, "R4 erase polls until clear", 32'(polls - p0), 32'(WIP_N + 1));
        chk(txn - t0 == WIP_N + 3, {tag, " txn count"}, 32'(txn - t0), 32'(WIP_N + 3));
    endtask

    task automatic do_prog(input int a, input logic [31:0] d, input string tag);
        int p0 = polls, g0 = progs;
        request(0, 0, 1, 24'(a), d);
        wait_done(tag);
        for (int i = 0; i < 4; i++) expm[(a + i) % 1024] &= d[31 - 8*i -: 8];
        chk(polls - p0 == WIP_N + 1, "R4 program polls until clear", 32'(polls - p0), 32'(WIP_N + 1));
        chk(progs - g0 == 1, {tag, " program accepted"}, 32'(progs - g0), 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, e0, n;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) begin mem[i] = pat(i); expm[i] = pat(i); end

        // R11 reset state
        repeat (4) @(negedge clk);
        chk(spi_cs_n === 1'b1, "R11 cs high in reset", 32'(spi_cs_n), 32'd1);
        chk(spi_sclk === 1'b0, "R11 sclk low in reset", 32'(spi_sclk), 32'd0);
        chk(done === 1'b0 && boot_valid === 1'b0, "R11 done/boot_valid low", 32'({done, boot_valid}), 32'd0);
        rst = 0;
        @(negedge clk);
        chk(busy === 1'b1, "R5 busy during startup", 32'(busy), 32'd1);

        // R5 startup reads
        n = 0;
        while (boot_valid !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        chk(boot_valid === 1'b1, "R5 boot_valid", 32'(boot_valid), 32'd1);
        chk(boot_word0 === exp_word(BA0), "R5 boot_word0", boot_word0, exp_word(BA0));
        chk(boot_word1 === exp_word(BA1), "R5 boot_word1", boot_word1, exp_word(BA1));
        chk(reads == 2 && txn == 2, "R5 two startup reads", 32'(txn), 32'd2);
        @(negedge clk);
        chk(busy === 1'b0, "R5 idle after startup", 32'(busy), 32'd0);

        // R1 directed reads
        do_read(0, "R1 read at 0");
        do_read(1020, "R1 read at top");
        chk(last_op == 8'h03, "R1 read opcode", 32'(last_op), 32'h03);

        // R2 erase then R3 program
        do_erase(24'h0002A0, "R2 erase sector 2");
        do_read(24'h000200, "R2 erased reads ones");
        do_prog(24'h000204, 32'hA5C3_1E07, "R3 program word");
        do_read(24'h000204, "R3 readback");
        do_read(24'h000200, "R3 neighbour untouched");

        // R8 requests while busy
        t0 = txn;
        fork
            do_erase(24'h000300, "R8 erase");
            begin
                repeat (6) @(negedge clk);
                req_read = 1; req_prog = 1; req_addr = 24'h000010;
                @(negedge clk);
                req_read = 0; req_prog = 0;
            end
        join
        chk(txn - t0 == WIP_N + 3, "R8 ignored requests start nothing", 32'(txn - t0), 32'(WIP_N + 3));
        chk(last_op == 8'h05, "R8 last txn is a poll", 32'(last_op), 32'h05);

        // R9 priority
        t0 = txn;
        request(1, 1, 1, 24'h000040, 32'h0);
        wait_done("R9 read wins");
        chk(txn - t0 == 1 && last_op == 8'h03, "R9 read before erase/program", 32'(last_op), 32'h03);
        chk(rd_data === exp_word(24'h40), "R9 read data", rd_data, exp_word(24'h40));
        e0 = erases; t0 = progs;
        request(0, 1, 1, 24'h000100, 32'h0);
        wait_done("R9 erase wins");
        for (int i = 0; i < 256; i++) expm[256 + i] = 8'hFF;
        chk(erases - e0 == 1 && progs == t0, "R9 erase before program", 32'(erases - e0), 32'd1);

        // random update/read mix
        for (int k = 0; k < 10; k++) begin
            int a = ($urandom % 256) * 4;
            logic [31:0] d = $urandom;
            if (k % 3 == 0) do_erase(a, "R2 random erase");
            do_prog(a, d, "R3 random program");
            do_read(a, "R1 random readback");
            do_read(($urandom % 1021), "R1 random read");
        end

        chk(perr == 0, "R6/R7 serial timing and protocol errors", 32'(perr), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule